// File: doc/BRIEF.md
# Oscillator Repeating-Pattern Alarm Monitor

This block watches the sampled output bits of a bank of free-running entropy oscillators and looks for channels that have become stuck or settled into a short repeating pattern. Each channel has its own detector. On every strobe of the shared sample strobe, the detector compares the new sample with the samples taken one, two, three and four strobes earlier. It counts how many strobes in a row have matched at least one of those earlier samples. When that run reaches the programmed alarm threshold, the channel raises an alarm event, and the event is logged.

If a channel alarms while its log bit is still set from an earlier alarm, it is shut down. Its stop flag is latched, and the flag keeps the channel's enable bit at 0 until software clears the flag and writes the enable bit again. The number of stopped channels is counted continuously. When that count first rises above a programmable threshold, the block emits a one-cycle overflow pulse. Software reaches the enable, log and stop registers through plain write strobes. The bus fabric lies outside this block.

Top module: `osc_alarm_mon`

## Requirements
- R1: After reset, all enable bits are 1. Log bits, stop flags, the shutdown count and the overflow pulse are all 0.
- R2: An enabled detector changes state only on a clock edge at which the sample strobe is high. On such an edge, the run count rises by 1 if the new sample equals any of the last 1, 2, 3 or 4 samples taken since the channel was enabled. Otherwise the run count returns to 0.
- R3: An alarm event occurs on a strobe edge at which the incremented run count equals the non-zero alarm threshold. At that edge the channel's log bit is set and its run count restarts at 0. A threshold of 0 never alarms.
- R4: An alarm on a channel whose log bit is already 1 sets that channel's stop flag at the same edge. The same edge clears the channel's enable bit.
- R5: An enable write stores the written bits, except that any bit whose stop flag is set before or after that edge is stored as 0. An enable bit is never 1 while its stop flag is 1.
- R6: Writes to the log and stop registers clear each bit written as 0 and keep each bit written as 1, so a write never sets a bit. An alarm at the same edge takes precedence over the clear.
- R7: The shutdown count equals the number of set stop flags. It follows the stop flags in the same cycle.
- R8: The overflow output is high for exactly one cycle. That cycle begins one clock edge after the edge at which the shutdown count first becomes strictly greater than the shutdown threshold.
- R9: A disabled channel discards its sample history and run count, and it raises no alarm. After re-enabling, it needs a fresh history before it can alarm again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smpl_stb_i | input | 1 | Shared sample strobe |
| smpl_bits_i | input | NUM_CH | One sampled oscillator bit per channel |
| alarm_thr_i | input | THR_W | Run length that declares an alarm |
| shut_thr_i | input | SHUT_THR_W | Stopped-channel count threshold |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NUM_CH | Enable write data |
| log_wr_i | input | 1 | Write strobe for the log register |
| log_wdata_i | input | NUM_CH | Log write data (0 clears a bit) |
| stop_wr_i | input | 1 | Write strobe for the stop register |
| stop_wdata_i | input | NUM_CH | Stop write data (0 clears a bit) |
| en_o | output | NUM_CH | Effective channel enables |
| log_o | output | NUM_CH | Alarm log bits |
| stop_o | output | NUM_CH | Stop flags |
| shut_cnt_o | output | CNT_W | Number of set stop flags |
| ovf_o | output | 1 | One-cycle shutdown overflow pulse |

## Verification
The log bits, stop flags and enable bits all change at the same clock edge that samples the deciding strobe, write or alarm. The shutdown count follows the stop flags within that same cycle. The overflow pulse arrives one edge later. The bench drives its inputs just after a rising edge and updates a reference model for the following edge. It then compares all outputs 1 ns after that edge, so each result is checked in exactly the cycle in which it is due. The directed runs count strobes by hand: with a threshold of 3 on a constant stream, the log bit must be clear after the third strobe and set after the fourth.

// File: rtl/osc_alarm_pkg.sv
package osc_alarm_pkg;
  localparam int unsigned DEF_NUM_CH     = 24;
  localparam int unsigned DEF_THR_W      = 8;
  localparam int unsigned DEF_SHUT_THR_W = 5;
  localparam int unsigned DEF_MAX_PER    = 4;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/osc_pattern_det.sv
module osc_pattern_det #(
  parameter int unsigned THR_W   = osc_alarm_pkg::DEF_THR_W,
  parameter int unsigned MAX_PER = osc_alarm_pkg::DEF_MAX_PER
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             smpl_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             alarm_o
);
  localparam int unsigned FILL_W = $clog2(MAX_PER + 1);

  logic [MAX_PER-1:0] hist_q;
  logic [FILL_W-1:0]  fill_q;
  logic [THR_W-1:0]   run_q, run_inc;
  logic [MAX_PER-1:0] per_hit;
  logic               match, hit_thr;

  // hist_q[p] holds the sample taken p+1 strobes ago
  for (genvar p = 0; p < MAX_PER; p++) begin : g_per
    assign per_hit[p] = (fill_q > FILL_W'(p)) && (hist_q[p] == smpl_i);
  end

  assign match   = |per_hit;
  assign run_inc = (&run_q) ? run_q : run_q + 1'b1;
  assign hit_thr = (thr_i != '0) && (run_inc == thr_i);
  assign alarm_o = en_i && stb_i && match && hit_thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
      run_q  <= '0;
    end else if (!en_i) begin
      hist_q <= '0;
      fill_q <= '0;
      run_q  <= '0;
    end else if (stb_i) begin
      hist_q <= MAX_PER'({hist_q, smpl_i});
      fill_q <= (fill_q == FILL_W'(MAX_PER)) ? fill_q : fill_q + 1'b1;
      run_q  <= (!match || hit_thr) ? '0 : run_inc;
    end
  end

  AST_DET_HOLD_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stb_i) |=> ($stable(run_q) && $stable(hist_q))); // R2
  AST_DET_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (run_q == '0 && fill_q == '0)); // R9
  AST_DET_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(MAX_PER)); // R2
  AST_DET_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> (run_q == '0)); // R3
endmodule

// File: rtl/osc_popcount.sv
module osc_popcount #(
  parameter int unsigned N = osc_alarm_pkg::DEF_NUM_CH,
  parameter int unsigned W = $clog2(N + 1)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) begin
      cnt_o = cnt_o + W'(bits_i[i]);
    end
  end
endmodule

// File: rtl/osc_ovf_pulse.sv
module osc_ovf_pulse #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned THR_W = osc_alarm_pkg::DEF_SHUT_THR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             pulse_o
);
  localparam int unsigned CMP_W = osc_alarm_pkg::max_u(CNT_W, THR_W);

  logic [CMP_W-1:0] cnt_ext, thr_ext;
  logic             above, above_q, pulse_q;

  assign cnt_ext = CMP_W'(cnt_i);
  assign thr_ext = CMP_W'(thr_i);
  assign above   = cnt_ext > thr_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      above_q <= above;
      pulse_q <= above && !above_q;
    end
  end

  assign pulse_o = pulse_q;

  AST_OVF_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R8
endmodule

// File: rtl/osc_alarm_mon.sv
module osc_alarm_mon #(
  parameter int unsigned NUM_CH     = osc_alarm_pkg::DEF_NUM_CH,
  parameter int unsigned THR_W      = osc_alarm_pkg::DEF_THR_W,
  parameter int unsigned SHUT_THR_W = osc_alarm_pkg::DEF_SHUT_THR_W,
  parameter int unsigned MAX_PER    = osc_alarm_pkg::DEF_MAX_PER,
  localparam int unsigned CNT_W     = $clog2(NUM_CH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  smpl_stb_i,
  input  logic [NUM_CH-1:0]     smpl_bits_i,
  input  logic [THR_W-1:0]      alarm_thr_i,
  input  logic [SHUT_THR_W-1:0] shut_thr_i,
  input  logic                  en_wr_i,
  input  logic [NUM_CH-1:0]     en_wdata_i,
  input  logic                  log_wr_i,
  input  logic [NUM_CH-1:0]     log_wdata_i,
  input  logic                  stop_wr_i,
  input  logic [NUM_CH-1:0]     stop_wdata_i,
  output logic [NUM_CH-1:0]     en_o,
  output logic [NUM_CH-1:0]     log_o,
  output logic [NUM_CH-1:0]     stop_o,
  output logic [CNT_W-1:0]      shut_cnt_o,
  output logic                  ovf_o
);
  logic [NUM_CH-1:0] en_q, log_q, stop_q;
  logic [NUM_CH-1:0] en_d, log_d, stop_d;
  logic [NUM_CH-1:0] alarm;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    osc_pattern_det #(
      .THR_W   (THR_W),
      .MAX_PER (MAX_PER)
    ) u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q[c]),
      .stb_i   (smpl_stb_i),
      .smpl_i  (smpl_bits_i[c]),
      .thr_i   (alarm_thr_i),
      .alarm_o (alarm[c])
    );
  end

  // alarm wins over a same-edge clear; a repeat alarm while logged stops the channel
  always_comb begin
    log_d  = (log_wr_i  ? (log_q  & log_wdata_i)  : log_q)  | alarm;
    stop_d = (stop_wr_i ? (stop_q & stop_wdata_i) : stop_q) | (alarm & log_q);
    en_d   = (en_wr_i ? en_wdata_i : en_q) & ~(stop_q | stop_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '1;
      log_q  <= '0;
      stop_q <= '0;
    end else begin
      en_q   <= en_d;
      log_q  <= log_d;
      stop_q <= stop_d;
    end
  end

  osc_popcount #(
    .N (NUM_CH),
    .W (CNT_W)
  ) u_cnt (
    .bits_i (stop_q),
    .cnt_o  (shut_cnt_o)
  );

  osc_ovf_pulse #(
    .CNT_W (CNT_W),
    .THR_W (SHUT_THR_W)
  ) u_ovf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (shut_cnt_o),
    .thr_i   (shut_thr_i),
    .pulse_o (ovf_o)
  );

  assign en_o   = en_q;
  assign log_o  = log_q;
  assign stop_o = stop_q;

  AST_STOP_GATES_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & stop_o) == '0); // R5
  AST_CNT_TRACKS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(shut_cnt_o) == $countones(stop_o)); // R7
  AST_STOP_NEEDS_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o & ~$past(stop_o) & ~$past(log_o)) == '0); // R4
  AST_STOP_NEW_ALSO_LOGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o & ~$past(stop_o) & ~log_o) == '0); // R6
endmodule

// File: tb/osc_alarm_mon_bench.sv
module osc_alarm_mon_bench;
  localparam int NCH = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stb = 1'b0;
  logic [NCH-1:0]  bits = '0;
  logic [7:0]      athr = 8'd3;
  logic [4:0]      sthr = 5'd0;
  logic            en_wr = 1'b0, log_wr = 1'b0, stop_wr = 1'b0;
  logic [NCH-1:0]  en_wd = '0, log_wd = '0, stop_wd = '0;
  logic [NCH-1:0]  en_o, log_o, stop_o;
  logic [4:0]      cnt_o;
  logic            ovf_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [NCH-1:0] m_en, m_log, m_stop;
  logic [3:0]     m_hist [NCH];
  int             m_fill [NCH];
  int             m_run  [NCH];
  logic           m_above, m_ovf;

  always #2.5 clk = ~clk;

  osc_alarm_mon u_osc_alarm_mon (
    .clk_i(clk), .rst_ni(rst_n), .smpl_stb_i(stb), .smpl_bits_i(bits),
    .alarm_thr_i(athr), .shut_thr_i(sthr),
    .en_wr_i(en_wr), .en_wdata_i(en_wd), .log_wr_i(log_wr), .log_wdata_i(log_wd),
    .stop_wr_i(stop_wr), .stop_wdata_i(stop_wd),
    .en_o(en_o), .log_o(log_o), .stop_o(stop_o), .shut_cnt_o(cnt_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [NCH-1:0] v);
    int n = 0;
    for (int i = 0; i < NCH; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic model_reset();
    m_en = '1; m_log = '0; m_stop = '0; m_above = 1'b0; m_ovf = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      m_hist[i] = '0; m_fill[i] = 0; m_run[i] = 0;
    end
  endtask

  // advance model by one clock edge using the current inputs
  task automatic model_step();
    logic [NCH-1:0] alarm, nlog, nstop, nen;
    logic above;
    alarm = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!m_en[i]) begin
        m_hist[i] = '0; m_fill[i] = 0; m_run[i] = 0;
      end else if (stb) begin
        logic hit;
        int inc;
        hit = 1'b0;
        for (int p = 0; p < 4; p++)
          if (m_fill[i] > p && m_hist[i][p] == bits[i]) hit = 1'b1;
        inc = (m_run[i] == 255) ? 255 : m_run[i] + 1;
        if (hit && athr != 0 && inc == int'(athr)) alarm[i] = 1'b1;
        m_run[i]  = (!hit || alarm[i]) ? 0 : inc;
        m_hist[i] = {m_hist[i][2:0], bits[i]};
        if (m_fill[i] < 4) m_fill[i]++;
      end
    end
    above = popc(m_stop) > int'(sthr);
    m_ovf = above && !m_above;
    m_above = above;
    nlog  = (log_wr ? (m_log & log_wd) : m_log) | alarm;
    nstop = (stop_wr ? (m_stop & stop_wd) : m_stop) | (alarm & m_log);
    nen   = (en_wr ? en_wd : m_en) & ~(m_stop | nstop);
    m_log = nlog; m_stop = nstop; m_en = nen;
  endtask

  task automatic cmp_all();
    chk("R5 en", 32'(en_o), 32'(m_en));
    chk("R3 log", 32'(log_o), 32'(m_log));
    chk("R4 stop", 32'(stop_o), 32'(m_stop));
    chk("R7 count", 32'(cnt_o), 32'(popc(m_stop)));
    chk("R8 ovf", 32'(ovf_o), 32'(m_ovf));
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    cmp_all();
    en_wr = 1'b0; log_wr = 1'b0; stop_wr = 1'b0; stb = 1'b0;
  endtask

  task automatic strobe(input int ch, input logic v);
    bits[ch] = v; stb = 1'b1;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_0a1a);
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 en reset", 32'(en_o), 32'hFF_FFFF);
    chk("R1 log reset", 32'(log_o), 0);
    chk("R1 stop reset", 32'(stop_o), 0);
    chk("R1 count reset", 32'(cnt_o), 0);
    chk("R1 ovf reset", 32'(ovf_o), 0);

    // only channel 0 enabled
    en_wr = 1'b1; en_wd = 24'h1; cycle();
    chk("R5 write en", 32'(en_o), 1);

    // R3 constant stream, thr 3: alarm on the 4th strobe
    for (int k = 0; k < 3; k++) begin strobe(0, 1'b0); cycle(); end
    chk("R2 no alarm after 3 strobes", 32'(log_o[0]), 0);
    strobe(0, 1'b0);
    chk("R3 alarm on 4th strobe", 32'(log_o[0]), 1);
    chk("R3 no stop on first alarm", 32'(stop_o[0]), 0);
    // R4 second alarm 3 strobes later
    strobe(0, 1'b0); strobe(0, 1'b0);
    chk("R4 stop not yet", 32'(stop_o[0]), 0);
    strobe(0, 1'b0);
    chk("R4 stop latched", 32'(stop_o[0]), 1);
    chk("R4 en cleared", 32'(en_o[0]), 0);
    chk("R7 count one", 32'(cnt_o), 1);
    chk("R8 ovf not yet", 32'(ovf_o), 0);
    cycle();
    chk("R8 ovf pulse", 32'(ovf_o), 1);
    cycle();
    chk("R8 ovf one cycle", 32'(ovf_o), 0);
    // R5 stopped channel cannot be enabled
    en_wr = 1'b1; en_wd = 24'h1; cycle();
    chk("R5 en blocked by stop", 32'(en_o[0]), 0);
    // R6 writing ones keeps, zeros clear
    stop_wr = 1'b1; stop_wd = '1; log_wr = 1'b1; log_wd = '1; cycle();
    chk("R6 ones keep stop", 32'(stop_o), 1);
    chk("R6 ones never set log", 32'(log_o), 1);
    stop_wr = 1'b1; stop_wd = '0; log_wr = 1'b1; log_wd = '0; cycle();
    chk("R6 stop cleared", 32'(stop_o), 0);
    chk("R6 log cleared", 32'(log_o), 0);
    chk("R7 count zero", 32'(cnt_o), 0);

    // R2 broken run: ch1 0,0,1 resets run, then 1,1 not enough, 1 alarms
    en_wr = 1'b1; en_wd = 24'h2; cycle();
    strobe(1, 1'b0); strobe(1, 1'b0); strobe(1, 1'b1);
    strobe(1, 1'b1); strobe(1, 1'b1);
    chk("R2 run restarted after break", 32'(log_o[1]), 0);
    strobe(1, 1'b1);
    chk("R2 alarm after rebuilt run", 32'(log_o[1]), 1);

    // R9 disabled channel never alarms, then needs fresh history
    log_wr = 1'b1; log_wd = '0; en_wr = 1'b1; en_wd = 24'h0; cycle();
    for (int k = 0; k < 10; k++) strobe(2, 1'b1);
    chk("R9 disabled no alarm", 32'(log_o), 0);
    en_wr = 1'b1; en_wd = 24'h4; cycle();
    for (int k = 0; k < 3; k++) strobe(2, 1'b1);
    chk("R9 fresh history needed", 32'(log_o[2]), 0);
    strobe(2, 1'b1);
    chk("R9 alarm after refill", 32'(log_o[2]), 1);

    // R3 threshold zero never alarms
    athr = 8'd0; log_wr = 1'b1; log_wd = '0; cycle();
    for (int k = 0; k < 20; k++) strobe(2, 1'b1);
    chk("R3 zero threshold", 32'(log_o), 0);

    // R6 alarm beats same-edge clear
    athr = 8'd2; en_wr = 1'b1; en_wd = 24'h8; cycle();
    strobe(3, 1'b0); strobe(3, 1'b0);
    log_wr = 1'b1; log_wd = '0; strobe(3, 1'b0);
    chk("R6 alarm wins over clear", 32'(log_o[3]), 1);

    // random phase against the model
    en_wr = 1'b1; en_wd = '1; cycle();
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 99) < 2) athr = 8'($urandom_range(2, 6));
      if ($urandom_range(0, 99) < 2) sthr = 5'($urandom_range(0, 4));
      stb = ($urandom_range(0, 1) == 1);
      for (int i = 0; i < NCH; i++)
        if (i % 3 != 0 || $urandom_range(0, 9) == 0) bits[i] = 1'($urandom);
      if ($urandom_range(0, 99) < 4) begin
        en_wr = 1'b1; en_wd = NCH'($urandom) | NCH'($urandom);
      end
      if ($urandom_range(0, 99) < 4) begin log_wr = 1'b1; log_wd = NCH'($urandom); end
      if ($urandom_range(0, 99) < 3) begin stop_wr = 1'b1; stop_wd = NCH'($urandom); end
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule